// File: doc/BRIEF.md
# Three-Channel External Pin Interrupt Controller

This block watches three external request pins and turns activity on them into interrupt requests for a processor. Channels 0 and 1 can each be set to respond to a low level, to any change, to a falling edge or to a rising edge. Channel 2 responds to edges only, and a single sense bit picks the rising or the falling edge. Every pin passes through a two-stage synchronizer before detection. The synchronizer registers reset to logic high, so pins are expected to idle high. The detector looks only at the pin value and ignores the pin's direction.

Software sees three byte-wide registers through a simple write strobe and an address. The enable register at address 0 and the flag register at address 1 share one bit layout. The sense register is at address 2. An edge event sets the channel's flag. A flag clears when the processor acknowledges that channel, or when software writes a one to the flag bit. A channel in low-level mode keeps its flag at zero, and its request follows the synchronized pin for as long as the pin stays low. The controller offers one request at a time, together with a 2-bit channel index chosen by fixed priority, and takes a one-cycle acknowledge when the handler is entered.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A channel drives `irq_req` only while its enable bit and `gie` are both 1. When no channel qualifies, `irq_req` is 0.
- R2: For channels 0 and 1, the sense register bits [1:0] (channel 0) and [3:2] (channel 1) are encoded 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. A read of address 2 returns the register in bits [4:0] and zeros in bits [7:5].
- R3: Channel 2 is edge-only. Sense bit 4 = 0 selects the falling edge and = 1 selects the rising edge.
- R4: A selected edge or change sets the channel's flag whether or not the channel is enabled. A pin change driven before clock edge k shows in the flag register after clock edge k+2.
- R5: An acknowledge (`irq_ack` high while `irq_req` is high) clears only the flag of the channel on `irq_idx` in that cycle.
- R6: Writing to address 1 clears every flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R7: In low-level mode a channel's flag reads 0. Its request is present while the synchronized pin is low, starting two clock edges after the pin falls, and it goes away two edges after the pin rises.
- R8: The flag register holds channel 1 in bit 7, channel 0 in bit 6 and channel 2 in bit 5. Bits 4 to 0 read as zero. All flags reset to 0.
- R9: The enable register (address 0) uses the same bit layout as the flag register and resets to 0x00. Address 3 reads 0x00 and ignores writes.
- R10: With several channels pending, `irq_idx` gives channel 0 first, then channel 1, then channel 2. The index is encoded as the channel number.
- R11: If an edge event falls in the same cycle as a write-one clear or an acknowledge for that channel, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 3 | External request pins, bit n = channel n |
| gie | input | 1 | Global interrupt enable from the processor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 flags, 2 sense |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 2 | Channel number of the offered request |
| irq_ack | input | 1 | Handler entry acknowledge for the offered channel |

## Verification
A flag that is wrongly set or wrongly cleared shows up in the next read of address 1. If the channel is enabled under `gie`, it also changes `irq_req` and `irq_idx` in the same cycle. A bad sense decode or a bad synchronizer depth moves the flag edge away from the two-edge latency of R4 by at least a clock. A lost clear priority leaves the flag bit at 0 one clock after a coincident event. The bench compares every port against a cycle model on every clock, so any such fault is reported within one cycle of its first visible effect.

// File: rtl/extint_pkg.sv
// Package: shared constants and types for the external pin interrupt controller.
// Assumes a fixed set of three channels; the first NFULL have full sense fields.
package extint_pkg;
    localparam int NCH   = 3;
    localparam int NFULL = 2;
    localparam int SNS_W = 2 * NFULL + (NCH - NFULL);
    localparam int DW    = 8;

    localparam logic [1:0] ADDR_EN    = 2'd0;
    localparam logic [1:0] ADDR_FLAG  = 2'd1;
    localparam logic [1:0] ADDR_SENSE = 2'd2;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_t;

    // Bit position of a channel in the enable and flag registers.
    function automatic int flag_pos(int ch);
        case (ch)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/eirq_edge_detect.sv
// Module: synchronizes one request pin and decodes the event that its sense field selects.
// Assumes the pin idles high: the synchronizer resets to ones, so no event appears at reset.
module eirq_edge_detect
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit FULL_SENSE  = 1'b1,
    parameter int SW          = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic [SW-1:0] sense_i,
    output logic          event_o,
    output logic          level_mode_o,
    output logic          level_low_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sample;
    logic                   rise;
    logic                   fall;

    // Shift the pin through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign sample = sync_q[SYNC_STAGES-1];
    assign rise   = sample & ~prev_q;
    assign fall   = ~sample & prev_q;

    generate
        if (FULL_SENSE) begin : g_full
            // Decode the four-way sense field.
            always_comb begin
                level_mode_o = 1'b0;
                event_o      = 1'b0;
                case (sense_t'(sense_i))
                    SNS_LOW:  level_mode_o = 1'b1;
                    SNS_ANY:  event_o      = rise | fall;
                    SNS_FALL: event_o      = fall;
                    default:  event_o      = rise;
                endcase
            end
        end else begin : g_edge
            // Edge-only channel: one bit picks the direction.
            assign event_o      = sense_i[0] ? rise : fall;
            assign level_mode_o = 1'b0;
        end
    endgenerate

    assign level_low_o = level_mode_o & ~sample;

    // Once in level mode, a low level is reported and never an edge event.
    assert_level_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode_o |-> !event_o);
endmodule

// File: rtl/eirq_flag_cell.sv
// Module: the flag bit of one channel, with set, write-one clear and acknowledge clear.
// Assumes an event has priority over both clears; level mode forces the flag to zero.
module eirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_wr_i,
    input  logic clr_ack_i,
    input  logic level_mode_i,
    output logic flag_o
);
    logic flag_q;

    // Update the flag: level mode first, then event, then the clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (level_mode_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_wr_i || clr_ack_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    assert_level_flag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode_i |=> !flag_o);
    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !level_mode_i) |=> flag_o);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ack_i && !set_i) |=> !flag_o);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/eirq_prio.sv
// Module: fixed-priority pick among pending channels, lowest channel number first.
// Assumes the pending vector is already qualified by the enables.
module eirq_prio #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend_i,
    output logic          req_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so that the lowest pending channel is the one kept.
    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                req_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

    assert_idx_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> pend_i[idx_o]);

    genvar g;
    generate
        for (g = 0; g < N - 1; g++) begin : g_chk
            assert_no_lower_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (req_o && (idx_o > IW'(g))) |-> !pend_i[g]);
        end
    endgenerate
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: three-channel external pin interrupt controller with enable, flag and sense registers.
// Assumes a single-cycle register write strobe and combinational reads at reg_addr.
module ext_irq_ctrl
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic          gie,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_req,
    output logic [1:0]    irq_idx,
    input  logic          irq_ack
);
    localparam int IW = 2;

    logic [NCH-1:0]   en_q;
    logic [SNS_W-1:0] sense_q;
    logic [NCH-1:0]   ev;
    logic [NCH-1:0]   lvl_mode;
    logic [NCH-1:0]   lvl_low;
    logic [NCH-1:0]   flag;
    logic [NCH-1:0]   pend;
    logic             wr_en;
    logic             wr_flag;
    logic             wr_sense;

    assign wr_en    = reg_wr && (reg_addr == ADDR_EN);
    assign wr_flag  = reg_wr && (reg_addr == ADDR_FLAG);
    assign wr_sense = reg_wr && (reg_addr == ADDR_SENSE);

    // Hold the sense field, loaded by writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) sense_q <= '0;
        else if (wr_sense) sense_q <= reg_wdata[SNS_W-1:0];
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            localparam bit FULL = (c < NFULL);
            localparam int SW   = FULL ? 2 : 1;
            localparam int SLO  = FULL ? 2 * c : 2 * NFULL + (c - NFULL);
            localparam int RB   = flag_pos(c);

            // Load this channel's enable bit from its register position.
            always_ff @(posedge clk) begin
                if (!rst_n) en_q[c] <= 1'b0;
                else if (wr_en) en_q[c] <= reg_wdata[RB];
            end

            eirq_edge_detect #(
                .SYNC_STAGES(SYNC_STAGES),
                .FULL_SENSE (FULL),
                .SW         (SW)
            ) u_det (
                .clk         (clk),
                .rst_n       (rst_n),
                .pin_i       (pin_in[c]),
                .sense_i     (sense_q[SLO +: SW]),
                .event_o     (ev[c]),
                .level_mode_o(lvl_mode[c]),
                .level_low_o (lvl_low[c])
            );

            eirq_flag_cell u_flag (
                .clk         (clk),
                .rst_n       (rst_n),
                .set_i       (ev[c]),
                .clr_wr_i    (wr_flag && reg_wdata[RB]),
                .clr_ack_i   (irq_ack && irq_req && (irq_idx == IW'(c))),
                .level_mode_i(lvl_mode[c]),
                .flag_o      (flag[c])
            );

            assign pend[c] = en_q[c] && gie && (lvl_mode[c] ? lvl_low[c] : flag[c]);
        end
    endgenerate

    eirq_prio #(.N(NCH), .IW(IW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend_i(pend),
        .req_o (irq_req),
        .idx_o (irq_idx)
    );

    // Assemble read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_EN:    for (int i = 0; i < NCH; i++) reg_rdata[flag_pos(i)] = en_q[i];
            ADDR_FLAG:  for (int i = 0; i < NCH; i++) reg_rdata[flag_pos(i)] = flag[i];
            ADDR_SENSE: reg_rdata[SNS_W-1:0] = sense_q;
            default:    reg_rdata = '0;
        endcase
    end

    assert_req_needs_gie_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);
    assert_req_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> en_q[irq_idx]);
    assert_idx_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_idx < IW'(NCH)));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
// Bench: directed corner cases followed by seeded random traffic, all compared against a cycle model.
module ext_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] pin_in;
    logic       gie;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [1:0] irq_idx;
    logic       irq_ack;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack)
    );

    // ---- reference model built from the requirements ----
    logic [2:0] m_s1, m_s2, m_p, m_en, m_flag;
    logic [4:0] m_sns;
    logic       m_req;
    logic [1:0] m_idx;
    logic [7:0] m_rd;

    function automatic int bitpos(int ch);
        return (ch == 0) ? 6 : (ch == 1) ? 7 : 5;
    endfunction

    function automatic logic is_lvl(int ch, logic [4:0] s);
        if (ch == 0) return s[1:0] == 2'b00;
        if (ch == 1) return s[3:2] == 2'b00;
        return 1'b0;
    endfunction

    // R2, R3: event from the sense code and the synchronized pin now and one clock earlier.
    function automatic logic evt(int ch, logic [4:0] s, logic now, logic old);
        logic [1:0] code;
        if (ch == 2) return s[4] ? (now & ~old) : (~now & old);
        code = (ch == 0) ? s[1:0] : s[3:2];
        case (code)
            2'b01:   return now != old;
            2'b10:   return ~now & old;
            2'b11:   return now & ~old;
            default: return 1'b0;
        endcase
    endfunction

    always_comb begin
        m_req = 1'b0;
        m_idx = 2'd0;
        for (int ch = 2; ch >= 0; ch--) begin
            if (m_en[ch] && gie && (is_lvl(ch, m_sns) ? !m_s2[ch] : m_flag[ch])) begin
                m_req = 1'b1;
                m_idx = 2'(ch);
            end
        end
        m_rd = 8'h00;
        case (reg_addr)
            2'd0: for (int ch = 0; ch < 3; ch++) m_rd[bitpos(ch)] = m_en[ch];
            2'd1: for (int ch = 0; ch < 3; ch++) m_rd[bitpos(ch)] = m_flag[ch];
            2'd2: m_rd = {3'b000, m_sns};
            default: m_rd = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 3'b111; m_s2 <= 3'b111; m_p <= 3'b111;
            m_en <= 3'b000; m_flag <= 3'b000; m_sns <= 5'b00000;
        end else begin
            for (int ch = 0; ch < 3; ch++) begin
                if (is_lvl(ch, m_sns))
                    m_flag[ch] <= 1'b0;
                else if (evt(ch, m_sns, m_s2[ch], m_p[ch]))
                    m_flag[ch] <= 1'b1;
                else if ((reg_wr && reg_addr == 2'd1 && reg_wdata[bitpos(ch)]) ||
                         (irq_ack && m_req && m_idx == 2'(ch)))
                    m_flag[ch] <= 1'b0;
                if (reg_wr && reg_addr == 2'd0) m_en[ch] <= reg_wdata[bitpos(ch)];
            end
            if (reg_wr && reg_addr == 2'd2) m_sns <= reg_wdata[4:0];
            m_s1 <= pin_in; m_s2 <= m_s1; m_p <= m_s2;
        end
    end

    // ---- checking helpers ----
    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        check("R2/R3/R4/R6/R8/R9 rdata", reg_rdata, m_rd);
        check("R1/R7 irq_req", {7'd0, irq_req}, {7'd0, m_req});
        if (m_req) check("R10/R5 irq_idx", {6'd0, irq_idx}, {6'd0, m_idx});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
        reg_addr = 2'd1;
        #1;
    endtask

    // ---- watchdog ----
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---- stimulus ----
    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pin_in = 3'b111; gie = 1'b0; reg_wr = 1'b0;
        reg_addr = 2'd1; reg_wdata = 8'h00; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8, R9, R1: reset state
        peek(2'd1, "R8 flags after reset", 8'h00);
        peek(2'd0, "R9 enables after reset", 8'h00);
        peek(2'd3, "R9 address 3 reads zero", 8'h00);
        check("R1 no request after reset", {7'd0, irq_req}, 8'h00);

        // R2, R3: ch0 falling, ch1 rising, ch2 rising
        wr_reg(2'd2, 8'h1E);
        peek(2'd2, "R2 sense readback", 8'h1E);
        wr_reg(2'd3, 8'hFF);
        peek(2'd0, "R9 address 3 write ignored", 8'h00);

        // R4: latency of a falling edge on channel 0, enable clear
        pin_in[0] = 1'b0;
        tick(); tick();
        peek(2'd1, "R4 flag not yet set", 8'h00);
        tick();
        peek(2'd1, "R4 flag set by falling edge", 8'h40);
        check("R1 no request while disabled", {7'd0, irq_req}, 8'h00);

        // R6: write-one clear
        wr_reg(2'd1, 8'h00);
        peek(2'd1, "R6 writing zero keeps flag", 8'h40);
        wr_reg(2'd1, 8'h40);
        peek(2'd1, "R6 writing one clears flag", 8'h00);

        // R11: event and write-one clear in the same cycle
        pin_in[0] = 1'b1;
        tick(); tick(); tick();
        peek(2'd1, "R2 rising edge ignored in falling mode", 8'h00);
        pin_in[0] = 1'b0;
        tick(); tick();
        wr_reg(2'd1, 8'h40);
        peek(2'd1, "R11 event beats clear", 8'h40);

        // R10, R5: set channel 1 and 2 flags by rising edges
        pin_in[2:1] = 2'b00;
        tick(); tick(); tick();
        pin_in[2:1] = 2'b11;
        tick(); tick(); tick();
        peek(2'd1, "R3 all flags set", 8'hE0);
        wr_reg(2'd0, 8'hE0);
        gie = 1'b1;
        tick();
        check("R10 channel 0 first", {6'd0, irq_idx}, 8'd0);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        peek(2'd1, "R5 ack clears only channel 0", 8'hA0);
        check("R10 channel 1 next", {6'd0, irq_idx}, 8'd1);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        peek(2'd1, "R5 ack clears channel 1", 8'h20);
        check("R10 channel 2 last", {6'd0, irq_idx}, 8'd2);
        gie = 1'b0;
        tick();
        check("R1 gie low blocks request", {7'd0, irq_req}, 8'h00);
        gie = 1'b1;

        // R7: channel 1 in low-level mode
        wr_reg(2'd2, 8'h12);
        pin_in[1] = 1'b0;
        tick(); tick();
        check("R7 level request on channel 1", {6'd0, irq_req, irq_idx}, 8'h05);
        peek(2'd1, "R7 level flag reads zero", 8'h20);
        pin_in[1] = 1'b1;
        tick(); tick();
        check("R7 level request ends", {6'd0, irq_req, irq_idx}, 8'h06);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < 3; b++)
                if ($urandom_range(7) == 0) pin_in[b] = ~pin_in[b];
            gie = ($urandom_range(7) != 0);
            irq_ack = m_req && ($urandom_range(1) == 1);
            if ($urandom_range(15) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 2'($urandom_range(3));
                reg_wdata = 8'($urandom);
            end else begin
                reg_wr = 1'b0;
                reg_addr = 2'($urandom_range(3));
            end
            tick();
        end
        reg_wr = 1'b0; irq_ack = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule